// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address. A request carries the address, the access kind, the privilege mode and the page table root. The block first checks that the address is properly sign-extended. It then takes one of two paths: a kernel superpage shortcut that needs no memory, or a walk through three levels of 8-byte table entries, read one at a time over a simple request/response memory port.

Each walk ends with a one-cycle `done` pulse. On success the block reports the physical address and the granted read/write/execute rights. On failure it reports a fault code, the faulting address and an access-type value. While the block is busy, requests are ignored.

The page size is 8 KB (13 offset bits), the implemented virtual width is 43 bits, and every level uses a 10-bit index. Rights are encoded as read = bit 0, write = bit 1, execute = bit 2. Access kinds are 0 = read, 1 = write, 2 = fetch and 3 = probe, which requests no right. Mode 0 is kernel.

Fault codes are 0 = none, 1 = access violation, 2 = entry not valid, 3 = fault-on-read, 4 = fault-on-write and 5 = fault-on-execute. The entry bits are:

| Entry bits | Meaning |
|------------|---------|
| 0 | valid |
| 1 | fault-on-read |
| 2 | fault-on-write |
| 3 | fault-on-execute |
| 8 + mode | read enable for that mode |
| 12 + mode | write enable for that mode |
| 63:32 | page frame number |

Top module: `pt_walker`

## Requirements
- R1: If address bits 63:43 are not all equal, the result is fault code 1 and no memory read is made.
- R2: A superpage address has bit 63 = 1 and bits 42:41 = 2'b10. A superpage access in any mode other than 0 gives fault code 1, with no memory read.
- R3: A superpage access in mode 0 succeeds with no memory read. The physical address keeps virtual bits 39:0, sets bit 43 to virtual bit 40 and clears all other bits. The rights are 3'b111.
- R4: Level 1 reads root + 8 × va[42:33]. Level 2 reads base + 8 × va[32:23]. Level 3 reads base + 8 × va[22:13]. The memory address stays stable while a read is pending.
- R5: The next table base, and the final physical address, is entry bits 63:32 shifted left by 13.
- R6: An entry at any level with bit 0 clear gives fault code 2, and the walk stops there.
- R7: A level-1 or level-2 entry without bit 8 set gives fault code 1.
- R8: In the leaf, bit 8+mode grants read and execute, and bit 12+mode grants write. A read, write or fetch that gets no matching right gives fault code 1. A probe never faults at the leaf.
- R9: Leaf bits 1, 2 and 3 remove the read, write and execute rights respectively. If the requested right is then gone, the fault code is 5 for a fetch, 4 for a write and 3 for a read. On success the reported rights are the ones that remain.
- R10: When `done` is high, `ok` is high exactly when the fault code is 0. On a fault the rights read zero, the reported address is the request address, and the access value is 2'b11 (−1) for a fetch and for a probe, and the access kind otherwise.
- R11: `busy` is high from the cycle after a request is accepted until `done` has pulsed for one cycle. Request inputs seen while busy are ignored.
- R12: After reset, `busy`, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_valid | input | 1 | start a translation (accepted when not busy) |
| req_vaddr | input | 64 | virtual address |
| req_acc | input | 2 | access kind: 0 read, 1 write, 2 fetch, 3 probe |
| req_mode | input | 2 | privilege mode, 0 = kernel |
| ptbr | input | 64 | level-1 table base |
| busy | output | 1 | translation in progress |
| mem_req | output | 1 | memory read pending |
| mem_addr | output | 64 | memory read address |
| mem_rsp_valid | input | 1 | read data valid |
| mem_rsp_data | input | 64 | read data (table entry) |
| done | output | 1 | one-cycle result strobe |
| ok | output | 1 | translation succeeded |
| phys | output | 64 | physical address |
| perm | output | 3 | granted rights {exec, write, read} |
| flt_code | output | 3 | fault code |
| flt_vaddr | output | 64 | faulting virtual address |
| flt_acc | output | 2 | access value reported with a fault |

## Verification
Random walks build a table chain for each address. Each level's valid and kernel-read bits, the leaf permission bits and the fault-on bits are randomised, across all four modes and all four access kinds. This separates valid faults at each level from permission faults and from fault-on faults. Directed cases cover the following:
- addresses that are badly sign-extended;
- superpage addresses in kernel and user mode, with virtual bit 40 set;
- a negative address outside the superpage;
- a probe against a leaf with no rights;
- a fetch blocked only by its fault-on bit;
- a request held, with changing inputs, through a whole walk.

The number of memory reads seen by the behavioural memory shows at which level each walk stopped.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_BITS   = 43,
  parameter int PAGE_BITS = 13,
  parameter int IDX_BITS  = 10,
  parameter int SP_LOW    = 40,
  parameter int SP_HI     = 43,
  parameter int V_BIT     = 0,
  parameter int FO_BIT    = 1,
  parameter int RD_BIT    = 8,
  parameter int WR_BIT    = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [63:0] req_vaddr,
  input  logic [1:0]  req_acc,
  input  logic [1:0]  req_mode,
  input  logic [63:0] ptbr,
  output logic        busy,
  output logic        mem_req,
  output logic [63:0] mem_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        done,
  output logic        ok,
  output logic [63:0] phys,
  output logic [2:0]  perm,
  output logic [2:0]  flt_code,
  output logic [63:0] flt_vaddr,
  output logic [1:0]  flt_acc
);
  localparam int SH3 = PAGE_BITS;
  localparam int SH2 = PAGE_BITS + IDX_BITS;
  localparam int SH1 = PAGE_BITS + 2 * IDX_BITS;
  localparam logic [2:0] FC_NONE = 3'd0, FC_ACV = 3'd1, FC_TNV = 3'd2,
                         FC_FOR = 3'd3, FC_FOW = 3'd4, FC_FOE = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_L1, S_L2, S_L3, S_DONE} st_t;
  st_t st;

  logic [63:0] va_q, base_q, phys_q;
  logic [1:0]  acc_q, mode_q;
  logic        ok_q;
  logic [2:0]  perm_q, code_q;

  logic sext_ok, kseg;
  assign sext_ok = (&req_vaddr[63:VA_BITS]) | ~(|req_vaddr[63:VA_BITS]);
  assign kseg    = req_vaddr[63] & (req_vaddr[VA_BITS-1 -: 2] == 2'b10);

  logic [63:0] kphys;
  assign kphys = 64'(req_vaddr[SP_LOW-1:0]) | (64'(req_vaddr[SP_LOW]) << SP_HI);

  logic [IDX_BITS-1:0] idx;
  always_comb begin
    case (st)
      S_L1:    idx = va_q[SH1 +: IDX_BITS];
      S_L2:    idx = va_q[SH2 +: IDX_BITS];
      default: idx = va_q[SH3 +: IDX_BITS];
    endcase
  end

  assign mem_req  = (st == S_L1) | (st == S_L2) | (st == S_L3);
  assign mem_addr = base_q + (64'(idx) << 3);

  logic [63:0] nxt_base;
  assign nxt_base = 64'(mem_rsp_data[63:32]) << PAGE_BITS;

  logic [2:0] need, grant, kept;
  logic       rd_en, wr_en;
  assign need  = (acc_q == 2'd3) ? 3'd0 : 3'(1 << acc_q);
  assign rd_en = mem_rsp_data[RD_BIT + 32'(mode_q)];
  assign wr_en = mem_rsp_data[WR_BIT + 32'(mode_q)];
  assign grant = {rd_en, wr_en, rd_en};
  assign kept  = grant & ~mem_rsp_data[FO_BIT +: 3];

  logic unused_bits;
  assign unused_bits = ^{mem_rsp_data[31:16], mem_rsp_data[7:4]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      va_q <= '0; base_q <= '0; phys_q <= '0;
      acc_q <= '0; mode_q <= '0;
      ok_q <= 1'b0; perm_q <= '0; code_q <= FC_NONE;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q <= req_vaddr; acc_q <= req_acc; mode_q <= req_mode; base_q <= ptbr;
          ok_q <= 1'b0; perm_q <= '0; phys_q <= '0; code_q <= FC_NONE;
          if (!sext_ok) begin
            code_q <= FC_ACV; st <= S_DONE;
          end else if (kseg) begin
            st <= S_DONE;
            if (req_mode != 2'd0) code_q <= FC_ACV;
            else begin ok_q <= 1'b1; perm_q <= 3'b111; phys_q <= kphys; end
          end else begin
            st <= S_L1;
          end
        end
        S_L1, S_L2: if (mem_rsp_valid) begin
          if (!mem_rsp_data[V_BIT]) begin
            code_q <= FC_TNV; st <= S_DONE;
          end else if (!mem_rsp_data[RD_BIT]) begin
            code_q <= FC_ACV; st <= S_DONE;
          end else begin
            base_q <= nxt_base;
            st <= (st == S_L1) ? S_L2 : S_L3;
          end
        end
        S_L3: if (mem_rsp_valid) begin
          st <= S_DONE;
          if (!mem_rsp_data[V_BIT]) code_q <= FC_TNV;
          else if (need != 3'd0 && (grant & need) == 3'd0) code_q <= FC_ACV;
          else if (need != 3'd0 && (kept & need) == 3'd0)
            code_q <= need[2] ? FC_FOE : (need[1] ? FC_FOW : FC_FOR);
          else begin ok_q <= 1'b1; perm_q <= kept; phys_q <= nxt_base; end
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign ok        = ok_q;
  assign phys      = phys_q;
  assign perm      = perm_q;
  assign flt_code  = code_q;
  assign flt_vaddr = va_q;
  assign flt_acc   = (acc_q[1]) ? 2'b11 : acc_q;

  assert_sext_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && !sext_ok) |=> (done && flt_code == FC_ACV && !mem_req));
  assert_kseg_user_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && sext_ok && kseg && req_mode != 2'd0) |=> (done && flt_code == FC_ACV));
  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr)));
  assert_ok_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((ok == (flt_code == FC_NONE)) && (ok || perm == 3'd0)));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  assert_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(flt_vaddr) && $stable(flt_acc));
  assert_memreq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy && !done);
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_vaddr = '0, ptbr = '0;
  logic [1:0]  req_acc = '0, req_mode = '0;
  logic        busy, mem_req, mem_rsp_valid = 1'b0, done, ok;
  logic [63:0] mem_addr, mem_rsp_data = '0, phys, flt_vaddr;
  logic [2:0]  perm, flt_code;
  logic [1:0]  flt_acc;

  int tests = 0, fails = 0, rd_cnt = 0;
  bit finished = 1'b0;
  logic [63:0] mem [logic [63:0]];

  always #2 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .req_mode(req_mode), .ptbr(ptbr), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .ok(ok), .phys(phys), .perm(perm),
    .flt_code(flt_code), .flt_vaddr(flt_vaddr), .flt_acc(flt_acc));

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [63:0] va, input logic [1:0] acc, input logic [1:0] mode,
                                input logic [63:0] root, output bit e_ok, output logic [63:0] e_phys,
                                output logic [2:0] e_perm, output logic [2:0] e_code, output int e_rd);
    logic [63:0] base, pte;
    logic [2:0]  need, pr;
    e_ok = 0; e_phys = 0; e_perm = 0; e_code = 3'd1; e_rd = 0;
    if (!(va[63:43] == 21'd0 || va[63:43] == 21'h1FFFFF)) return;
    if (va[63] && va[42:41] == 2'b10) begin
      if (mode != 0) return;
      e_ok = 1; e_code = 0; e_perm = 3'b111;
      e_phys = {20'd0, va[40], 3'd0, va[39:0]};
      return;
    end
    base = root;
    for (int lvl = 0; lvl < 3; lvl++) begin
      pte = rd(base + 8 * ((va >> (13 + 10 * (2 - lvl))) & 64'h3FF));
      e_rd++;
      if (!pte[0]) begin e_code = 3'd2; return; end
      if (lvl < 2) begin
        if (!pte[8]) begin e_code = 3'd1; return; end
        base = {pte[63:32], 13'd0} & 64'h001F_FFFF_FFFF_E000;
        base = (pte >> 32) << 13;
      end
    end
    need = (acc == 3) ? 3'd0 : (acc == 0 ? 3'd1 : acc == 1 ? 3'd2 : 3'd4);
    pr = 0;
    if (pte[8 + mode])  pr = pr | 3'b101;
    if (pte[12 + mode]) pr = pr | 3'b010;
    if (need != 0 && (pr & need) == 0) begin e_code = 3'd1; return; end
    pr = pr & ~pte[3:1];
    if (need != 0 && (pr & need) == 0) begin
      e_code = (acc == 2) ? 3'd5 : (acc == 1) ? 3'd4 : 3'd3;
      return;
    end
    e_ok = 1; e_code = 0; e_perm = pr; e_phys = (pte >> 32) << 13;
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_req) begin
        repeat ($urandom % 3) @(negedge clk);
        mem_rsp_data  = rd(mem_addr);
        mem_rsp_valid = 1'b1;
        rd_cnt++;
      end
    end
  end

  task automatic run(input logic [63:0] va, input logic [1:0] acc, input logic [1:0] mode,
                     input logic [63:0] root, input bit hold, input string tag);
    bit e_ok; logic [63:0] e_phys; logic [2:0] e_perm, e_code; int e_rd;
    string t;
    model(va, acc, mode, root, e_ok, e_phys, e_perm, e_code, e_rd);
    t = tag;
    if (tag == "") begin
      case (e_code)
        3'd0:    t = "R5";
        3'd2:    t = "R6";
        3'd1:    t = (e_rd == 3) ? "R8" : "R7";
        default: t = "R9";
      endcase
    end
    @(negedge clk);
    rd_cnt = 0;
    req_vaddr = va; req_acc = acc; req_mode = mode; ptbr = root; req_valid = 1'b1;
    @(negedge clk);
    if (hold) begin
      req_vaddr = ~va; req_acc = ~acc; req_mode = ~mode; ptbr = ~root;
    end else req_valid = 1'b0;
    while (!done) @(negedge clk);
    req_valid = 1'b0;
    chk({t, " ok"}, 64'(ok), 64'(e_ok));
    chk({t, " code"}, 64'(flt_code), 64'(e_code));
    chk("R4 reads", 64'(rd_cnt), 64'(e_rd));
    if (e_ok) begin
      chk({t, " phys"}, phys, e_phys);
      chk({t, " perm"}, 64'(perm), 64'(e_perm));
    end else begin
      chk("R10 vaddr", flt_vaddr, va);
      chk("R10 acc", 64'(flt_acc), 64'((acc >= 2) ? 2'b11 : acc));
      chk("R10 perm", 64'(perm), 64'd0);
    end
    @(negedge clk);
    chk("R11 done pulse", 64'(done), 64'd0);
    chk("R11 busy low", 64'(busy), 64'd0);
  endtask

  task automatic build(input logic [63:0] va, input logic [63:0] root, input logic [15:0] f1,
                       input logic [15:0] f2, input logic [15:0] f3, input logic [31:0] leaf_pfn);
    logic [31:0] p2, p3;
    p2 = 32'h200 + 32'($urandom_range(0, 255));
    p3 = 32'h400 + 32'($urandom_range(0, 255));
    mem[root + 8 * 64'(va[42:33])] = {p2, 16'd0, f1};
    mem[(64'(p2) << 13) + 8 * 64'(va[32:23])] = {p3, 16'd0, f2};
    mem[(64'(p3) << 13) + 8 * 64'(va[22:13])] = {leaf_pfn, 16'd0, f3};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] root, va;
    void'($urandom(32'h5EED_0017));
    repeat (3) @(negedge clk);
    chk("R12 busy", 64'(busy), 64'd0);
    chk("R12 done", 64'(done), 64'd0);
    chk("R12 mem_req", 64'(mem_req), 64'd0);
    rst_n = 1'b1;
    root = 64'h0010_0000;

    run(64'h0000_0800_0000_0000, 2'd0, 2'd0, root, 0, "R1");
    run(64'hFFFF_F000_0000_0000 ^ 64'h0001_0000_0000_0000, 2'd1, 2'd0, root, 0, "R1");
    run(64'hFFFF_FD12_3456_789A, 2'd2, 2'd0, root, 0, "R3");
    chk("R3 phys", phys, 64'h0000_0812_3456_789A);
    run(64'hFFFF_FD12_3456_789A, 2'd0, 2'd3, root, 0, "R2");
    run(64'hFFFF_FC00_0000_0000, 2'd1, 2'd1, root, 0, "R2");

    va = 64'h0000_0123_4567_8000;
    build(va, root, 16'h0101, 16'h0101, 16'h0001, 32'hABCD);
    run(va, 2'd3, 2'd2, root, 0, "R8");
    build(va, root, 16'h0101, 16'h0101, 16'h0109, 32'hABCD);
    run(va, 2'd2, 2'd0, root, 0, "R9");
    build(va, root, 16'h0101, 16'h0101, 16'h1207, 32'hABCD);
    run(va, 2'd0, 2'd1, root, 0, "R9");
    build(va, root, 16'h0001, 16'h0101, 16'h0101, 32'hABCD);
    run(va, 2'd0, 2'd0, root, 0, "R7");
    build(va, root, 16'h0101, 16'h0100, 16'h0101, 32'hABCD);
    run(va, 2'd0, 2'd0, root, 0, "R6");
    build(va, root, 16'h0101, 16'h0101, 16'h2201, 32'h1357);
    run(va, 2'd1, 2'd1, root, 1, "R11");
    va = 64'hFFFF_FE00_0000_4000;
    build(va, root, 16'h0101, 16'h0101, 16'h1101, 32'h2468);
    run(va, 2'd1, 2'd0, root, 0, "R5");

    for (int i = 0; i < 400; i++) begin
      logic [15:0] f1, f2, f3;
      logic [1:0] acc, mode;
      case ($urandom % 8)
        0:       va = {21'h1FFFFF, 43'($urandom) ^ {2'b10, 41'd0}, 43'd0} | 64'($urandom);
        1:       va = {$urandom, $urandom};
        default: va = {21'd0, 11'($urandom), $urandom};
      endcase
      va[63:43] = ($urandom % 8 == 0) ? va[63:43] : {21{va[63]}};
      f1 = {8'd0, 7'd0, 1'b1} | (($urandom % 8 != 0) ? 16'h0100 : 16'h0);
      f1[0] = ($urandom % 8 != 0);
      f2 = (($urandom % 8 != 0) ? 16'h0100 : 16'h0) | 16'(($urandom % 8 != 0));
      f3 = 16'($urandom) & 16'hFF0F;
      f3[0] = ($urandom % 8 != 0);
      acc  = 2'($urandom);
      mode = 2'($urandom);
      root = 64'h0010_0000 + (64'($urandom % 16) << 13);
      build(va, root, f1, f2, f3, $urandom);
      run(va, acc, mode, root, ($urandom % 16 == 0), "");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule